// File: doc/BRIEF.md
# Vectored interrupt state unit

This unit keeps the interrupt state of a simple 32-bit load/store processor. At every instruction boundary the control sequencer strobes it with the current program counter. If an external request is pending and interrupts are enabled, the unit takes the interrupt. It saves the program counter and the 16-bit cause word from the device, clears the enable flag and pulses an acknowledge. It then sends the processor to a vector built from the device's 8-bit type code. In every other case it hands back the sequential address, PC plus 4.

The unit also carries out the state effects of five instructions. These are return from interrupt, save of interrupt state to two registers, restore of interrupt state from two operands, and global enable and disable. There is one global enable flag and no priority levels. When several devices request at once, an external circuit arbitrates between them.

All results are registered. The next-PC value and its load strobe, the acknowledge and the save-state write strobe appear in the cycle after the clock edge that samples the boundary or instruction strobe.

Top module: `irq_state_unit`

## Requirements
- R1: After reset the enable flag is 0, `pc_load_o`, `irq_ack_o` and `sv_wr_o` are 0, and both save-state outputs read 0. A request at the first boundary therefore is not taken.
- R2: A boundary strobe with the request low, or with interrupts disabled, gives one cycle later `pc_load_o`=1, `pc_next_o`=`pc_i`+4 (modulo 2^32) and `irq_ack_o`=0.
- R3: A boundary strobe with the request high and interrupts enabled gives one cycle later `pc_load_o`=1 and `pc_next_o` with the type code in bits 11..4 and every other bit zero.
- R4: Taking an interrupt stores `pc_i` as the saved PC and `src_info_i` as the low 16 info bits. From the next cycle `sv_rb_o` shows the saved PC and `sv_ra_o` shows the info word, with its upper 16 bits always zero.
- R5: Taking an interrupt clears the enable flag. A request that stays high at later boundaries yields sequential fetch and no further acknowledge until interrupts are enabled again.
- R6: `irq_ack_o` is high for exactly one cycle per taken interrupt and never otherwise.
- R7: Opcode 29 (return, 5-bit opcode field) gives one cycle later `pc_load_o`=1 with `pc_next_o` equal to the saved PC, and it sets the enable flag on the same edge.
- R8: Opcode 16 (save state) gives a one-cycle `sv_wr_o` pulse one cycle later. During the pulse `sv_ra_o` holds the zero-extended info word and `sv_rb_o` holds the saved PC, and the interrupt state is left unchanged.
- R9: Opcode 17 (restore state) loads the info word from `rs_info_i` and the saved PC from `rs_pc_i`.
- R10: Opcode 10 sets the enable flag and opcode 11 clears it. Neither loads the PC.
- R11: An instruction strobe with `op_valid_i` low, an opcode outside 10, 11, 16, 17 and 29, or an instruction strobe in the same cycle as a boundary strobe has no effect. The boundary strobe takes precedence.
- R12: The request is sampled only on a boundary strobe. A request high in cycles without a boundary strobe produces no acknowledge and no PC load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 32 | Current program counter |
| irq_req_i | input | 1 | External interrupt request |
| src_info_i | input | 16 | Cause word from the requesting device |
| src_type_i | input | 8 | Type code from the requesting device |
| op_valid_i | input | 1 | Decoded instruction strobe |
| opcode_i | input | 5 | Decoded opcode |
| rs_info_i | input | 16 | Low 16 bits of operand ra, used by restore |
| rs_pc_i | input | 32 | Operand rb, used by restore |
| pc_next_o | output | 32 | Program counter to load |
| pc_load_o | output | 1 | One-cycle strobe: load `pc_next_o` |
| irq_ack_o | output | 1 | One-cycle interrupt acknowledge |
| sv_wr_o | output | 1 | One-cycle strobe: write save-state values to ra and rb |
| sv_ra_o | output | 32 | Zero-extended info word (value for ra) |
| sv_rb_o | output | 32 | Saved PC (value for rb) |

## Verification
The PC load, the acknowledge and the save-state write strobe are each due exactly one cycle after the edge that samples the boundary or instruction strobe. The saved PC, the info word and the enable flag take effect on that same edge. This shows in the save outputs from that cycle on, and in how the next boundary is treated. The bench drives each stimulus on the falling edge and queues the outputs it predicts for the next rising edge. It compares them one time unit after that edge, so that every prediction is paired with the single cycle in which it is due. The enable flag is checked only through its effect at a later boundary: acknowledge or sequential fetch.

// File: rtl/irq_state_pkg.sv
package irq_state_pkg;

    localparam int unsigned OPC_W = 5;

    localparam logic [OPC_W-1:0] OPC_EN_ALL  = 5'd10;
    localparam logic [OPC_W-1:0] OPC_DIS_ALL = 5'd11;
    localparam logic [OPC_W-1:0] OPC_SAVE    = 5'd16;
    localparam logic [OPC_W-1:0] OPC_RESTORE = 5'd17;
    localparam logic [OPC_W-1:0] OPC_RETURN  = 5'd29;

    typedef struct packed {
        logic en_all;
        logic dis_all;
        logic save;
        logic restore;
        logic ret;
    } irq_op_t;

endpackage

// File: rtl/irq_op_decode.sv
module irq_op_decode
    import irq_state_pkg::*;
(
    input  logic             valid_i,
    input  logic             block_i,
    input  logic [OPC_W-1:0] opcode_i,
    output irq_op_t          op_o
);
    logic live;

    always_comb begin
        live         = valid_i && !block_i;
        op_o         = '0;
        op_o.en_all  = live && (opcode_i == OPC_EN_ALL);
        op_o.dis_all = live && (opcode_i == OPC_DIS_ALL);
        op_o.save    = live && (opcode_i == OPC_SAVE);
        op_o.restore = live && (opcode_i == OPC_RESTORE);
        op_o.ret     = live && (opcode_i == OPC_RETURN);
    end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned TYPE_W  = 8,
    parameter int unsigned VEC_LSB = 4
) (
    input  logic [TYPE_W-1:0] type_i,
    output logic [XLEN-1:0]   vec_o
);
    localparam int unsigned VEC_MSB = VEC_LSB + TYPE_W - 1;

    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        if (b >= VEC_LSB && b <= VEC_MSB) begin : g_type
            assign vec_o[b] = type_i[b-VEC_LSB];
        end else begin : g_zero
            assign vec_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_state_unit.sv
module irq_state_unit
    import irq_state_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned INFO_W  = 16,
    parameter int unsigned TYPE_W  = 8,
    parameter int unsigned VEC_LSB = 4,
    parameter int unsigned PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              irq_req_i,
    input  logic [INFO_W-1:0] src_info_i,
    input  logic [TYPE_W-1:0] src_type_i,
    input  logic              op_valid_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [INFO_W-1:0] rs_info_i,
    input  logic [XLEN-1:0]   rs_pc_i,
    output logic [XLEN-1:0]   pc_next_o,
    output logic              pc_load_o,
    output logic              irq_ack_o,
    output logic              sv_wr_o,
    output logic [XLEN-1:0]   sv_ra_o,
    output logic [XLEN-1:0]   sv_rb_o
);
    localparam int unsigned     PAD_W    = XLEN - INFO_W;
    localparam logic [XLEN-1:0] STEP_VAL = XLEN'(PC_STEP);

    typedef struct packed {
        logic              ie;
        logic [XLEN-1:0]   epc;
        logic [INFO_W-1:0] info;
        logic [XLEN-1:0]   pc_nxt;
        logic              pc_ld;
        logic              ack;
        logic              sv_wr;
    } unit_state_t;

    unit_state_t s_d, s_q;
    irq_op_t     op;
    logic [XLEN-1:0] vec;
    logic        take;
    logic        irq_en_q;

    irq_op_decode u_dec (
        .valid_i  (op_valid_i),
        .block_i  (boundary_i),
        .opcode_i (opcode_i),
        .op_o     (op)
    );

    irq_vector_gen #(
        .XLEN    (XLEN),
        .TYPE_W  (TYPE_W),
        .VEC_LSB (VEC_LSB)
    ) u_vec (
        .type_i (src_type_i),
        .vec_o  (vec)
    );

    always_comb begin
        s_d       = s_q;
        s_d.pc_ld = 1'b0;
        s_d.ack   = 1'b0;
        s_d.sv_wr = 1'b0;
        take      = boundary_i && irq_req_i && s_q.ie;

        if (boundary_i) begin
            s_d.pc_ld = 1'b1;
            if (take) begin
                s_d.pc_nxt = vec;
                s_d.ack    = 1'b1;
                s_d.epc    = pc_i;
                s_d.info   = src_info_i;
                s_d.ie     = 1'b0;
            end else begin
                s_d.pc_nxt = pc_i + STEP_VAL;
            end
        end else begin
            if (op.ret) begin
                s_d.pc_ld  = 1'b1;
                s_d.pc_nxt = s_q.epc;
                s_d.ie     = 1'b1;
            end
            if (op.save) begin
                s_d.sv_wr = 1'b1;
            end
            if (op.restore) begin
                s_d.info = rs_info_i;
                s_d.epc  = rs_pc_i;
            end
            if (op.en_all) begin
                s_d.ie = 1'b1;
            end
            if (op.dis_all) begin
                s_d.ie = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_en_q  = s_q.ie;
    assign pc_next_o = s_q.pc_nxt;
    assign pc_load_o = s_q.pc_ld;
    assign irq_ack_o = s_q.ack;
    assign sv_wr_o   = s_q.sv_wr;
    assign sv_ra_o   = {{PAD_W{1'b0}}, s_q.info};
    assign sv_rb_o   = s_q.epc;
endmodule

// File: rtl/irq_state_unit_chk.sv
module irq_state_unit_chk
    import irq_state_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned INFO_W  = 16,
    parameter int unsigned TYPE_W  = 8,
    parameter int unsigned VEC_LSB = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             boundary_i,
    input logic             irq_req_i,
    input logic             op_valid_i,
    input logic [OPC_W-1:0] opcode_i,
    input logic [XLEN-1:0]  pc_next_o,
    input logic             pc_load_o,
    input logic             irq_ack_o,
    input logic [XLEN-1:0]  sv_ra_o,
    input logic             ie_q
);
    localparam logic [XLEN-1:0] VEC_MASK = XLEN'(((64'd1 << TYPE_W) - 64'd1) << VEC_LSB);

    logic ret_live, en_live, dis_live;
    assign ret_live = op_valid_i && !boundary_i && (opcode_i == OPC_RETURN);
    assign en_live  = op_valid_i && !boundary_i && (opcode_i == OPC_EN_ALL);
    assign dis_live = op_valid_i && !boundary_i && (opcode_i == OPC_DIS_ALL);

    AST_TAKE_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && irq_req_i && ie_q) |=> irq_ack_o); // R3
    AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |-> (pc_load_o && ((pc_next_o & ~VEC_MASK) == '0))); // R3
    AST_INFO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((sv_ra_o >> INFO_W) == '0)); // R4
    AST_TAKE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |-> !ie_q); // R5
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |=> !irq_ack_o); // R6
    AST_RETURN_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        ret_live |=> (ie_q && pc_load_o)); // R7
    AST_ENABLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        en_live |=> (ie_q && !pc_load_o)); // R10
    AST_DISABLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        dis_live |=> (!ie_q && !pc_load_o)); // R10
    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(boundary_i && irq_req_i && ie_q) |=> !irq_ack_o); // R12
    AST_LOAD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> $past(boundary_i || ret_live)); // R11
endmodule

bind irq_state_unit irq_state_unit_chk #(
    .XLEN    (XLEN),
    .INFO_W  (INFO_W),
    .TYPE_W  (TYPE_W),
    .VEC_LSB (VEC_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .irq_req_i  (irq_req_i),
    .op_valid_i (op_valid_i),
    .opcode_i   (opcode_i),
    .pc_next_o  (pc_next_o),
    .pc_load_o  (pc_load_o),
    .irq_ack_o  (irq_ack_o),
    .sv_ra_o    (sv_ra_o),
    .ie_q       (irq_en_q)
);

// File: tb/irq_state_unit_bench.sv
module irq_state_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        irq_req_i = 1'b0;
    logic [15:0] src_info_i = '0;
    logic [7:0]  src_type_i = '0;
    logic        op_valid_i = 1'b0;
    logic [4:0]  opcode_i = '0;
    logic [15:0] rs_info_i = '0;
    logic [31:0] rs_pc_i = '0;
    logic [31:0] pc_next_o;
    logic        pc_load_o, irq_ack_o, sv_wr_o;
    logic [31:0] sv_ra_o, sv_rb_o;

    irq_state_unit u_irq_state_unit (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .pc_i(pc_i),
        .irq_req_i(irq_req_i), .src_info_i(src_info_i), .src_type_i(src_type_i),
        .op_valid_i(op_valid_i), .opcode_i(opcode_i), .rs_info_i(rs_info_i),
        .rs_pc_i(rs_pc_i), .pc_next_o(pc_next_o), .pc_load_o(pc_load_o),
        .irq_ack_o(irq_ack_o), .sv_wr_o(sv_wr_o), .sv_ra_o(sv_ra_o), .sv_rb_o(sv_rb_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        load;
        logic [31:0] pc;
        logic        ack;
        logic        wr;
        logic [31:0] ra;
        logic [31:0] rb;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    // reference state, derived from the requirements
    logic        m_ie   = 1'b0;
    logic [31:0] m_epc  = '0;
    logic [15:0] m_info = '0;

    task automatic drive(input string tag, input logic bnd, input logic req,
                         input logic [31:0] pc, input logic [15:0] inf, input logic [7:0] typ,
                         input logic opv, input logic [4:0] opc,
                         input logic [15:0] ra, input logic [31:0] rb);
        exp_t e;
        @(negedge clk);
        boundary_i = bnd; irq_req_i = req; pc_i = pc; src_info_i = inf; src_type_i = typ;
        op_valid_i = opv; opcode_i = opc; rs_info_i = ra; rs_pc_i = rb;
        e = '0;
        if (bnd) begin
            e.load = 1'b1;
            if (req && m_ie) begin
                e.pc = {20'h0, typ, 4'h0};
                e.ack = 1'b1;
                m_epc = pc; m_info = inf; m_ie = 1'b0;
            end else begin
                e.pc = pc + 32'd4;
            end
        end else if (opv) begin
            case (opc)
                5'd29: begin e.load = 1'b1; e.pc = m_epc; m_ie = 1'b1; end
                5'd16: e.wr = 1'b1;
                5'd17: begin m_info = ra; m_epc = rb; end
                5'd10: m_ie = 1'b1;
                5'd11: m_ie = 1'b0;
                default: ;
            endcase
        end
        e.ra = {16'h0, m_info};
        e.rb = m_epc;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic bnd(input string tag, input logic req, input logic [31:0] pc,
                       input logic [15:0] inf, input logic [7:0] typ);
        drive(tag, 1'b1, req, pc, inf, typ, 1'b0, 5'd0, 16'h0, 32'h0);
    endtask

    task automatic op(input string tag, input logic [4:0] opc,
                      input logic [15:0] ra, input logic [31:0] rb);
        drive(tag, 1'b0, 1'b0, 32'h0, 16'h0, 8'h0, 1'b1, opc, ra, rb);
    endtask

    // monitor: one expected item per driven cycle, sampled after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (pc_load_o !== e.load || irq_ack_o !== e.ack || sv_wr_o !== e.wr ||
                    sv_ra_o !== e.ra || sv_rb_o !== e.rb || (e.load && pc_next_o !== e.pc)) begin
                    fails++;
                    $display("FAIL %s: got load=%0b pc=%h ack=%0b wr=%0b ra=%h rb=%h expected load=%0b pc=%h ack=%0b wr=%0b ra=%h rb=%h",
                             t, pc_load_o, pc_next_o, irq_ack_o, sv_wr_o, sv_ra_o, sv_rb_o,
                             e.load, e.pc, e.ack, e.wr, e.ra, e.rb);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion, expected completion within %0d cycles", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;   // R1 reset state
        if (pc_load_o !== 1'b0 || irq_ack_o !== 1'b0 || sv_wr_o !== 1'b0 ||
            sv_ra_o !== 32'h0 || sv_rb_o !== 32'h0) begin
            fails++;
            $display("FAIL R1: got load=%0b ack=%0b wr=%0b ra=%h rb=%h expected all zero",
                     pc_load_o, irq_ack_o, sv_wr_o, sv_ra_o, sv_rb_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        bnd("R1 disabled after reset", 1'b1, 32'h0000_0100, 16'h1111, 8'h11);
        drive("R12 request without boundary", 1'b0, 1'b1, 32'h0, 16'h0, 8'h0, 1'b0, 5'd0, 16'h0, 32'h0);
        op("R10 enable opcode 10", 5'd10, 16'h0, 32'h0);
        drive("R12 enabled, request without boundary", 1'b0, 1'b1, 32'h0, 16'h0, 8'h0, 1'b0, 5'd0, 16'h0, 32'h0);
        bnd("R3 R4 R6 take interrupt", 1'b1, 32'h1234_5670, 16'hBEEF, 8'hA5);
        drive("R6 ack dropped, R4 state held", 1'b0, 1'b1, 32'h0, 16'h0, 8'h0, 1'b0, 5'd0, 16'h0, 32'h0);
        bnd("R5 held request not retaken", 1'b1, 32'h0000_0A50, 16'h2222, 8'h22);
        op("R8 save state", 5'd16, 16'h0, 32'h0);
        op("R9 restore state", 5'd17, 16'h1357, 32'h0000_4444);
        op("R8 save after restore", 5'd16, 16'h0, 32'h0);
        op("R7 return from interrupt", 5'd29, 16'h0, 32'h0);
        bnd("R7 R3 re-enabled by return", 1'b1, 32'h0000_0008, 16'hCAFE, 8'hFF);
        op("R10 enable opcode 10", 5'd10, 16'h0, 32'h0);
        op("R10 disable opcode 11", 5'd11, 16'h0, 32'h0);
        bnd("R10 disabled, no entry", 1'b1, 32'h0000_2000, 16'h3333, 8'h33);
        drive("R11 return with valid low", 1'b0, 1'b0, 32'h0, 16'h0, 8'h0, 1'b0, 5'd29, 16'h0, 32'h0);
        op("R11 unknown opcode 5", 5'd5, 16'hFFFF, 32'hFFFF_FFFF);
        drive("R11 boundary wins over enable", 1'b1, 1'b0, 32'h0000_3000, 16'h0, 8'h0, 1'b1, 5'd10, 16'h0, 32'h0);
        bnd("R11 enable was ignored", 1'b1, 32'h0000_3004, 16'h4444, 8'h44);
        op("R10 enable opcode 10", 5'd10, 16'h0, 32'h0);
        bnd("R3 type code zero", 1'b1, 32'h0000_5000, 16'h0001, 8'h00);
        bnd("R2 PC wraps at top", 1'b0, 32'hFFFF_FFFC, 16'h0, 8'h0);

        @(negedge clk);
        boundary_i = 1'b0; op_valid_i = 1'b0; irq_req_i = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule